// File: doc/BRIEF.md
# Overlapping Register Window File

This block holds a processor's integer registers as a ring of overlapping windows and presents a fixed 32-entry view of them. The view is built from the current window pointer. Eight globals are shared by every window. Each window has eight private locals. Eight input registers belong to the window, and eight output registers are the input registers of the next window around the ring. A caller puts arguments in its outputs. After a save, the callee sees those same values as its inputs, and nothing is copied.

A save request moves to the next window and a restore request moves back. Both moves are modulo the window count. Two occupancy counters track the free and the restorable windows, and a third count covers windows that belong to another context. The sum of the three stays at the window count minus two. When a save finds no free window, the block raises an overflow trap request. When a restore finds nothing to restore, it raises an underflow trap request. In both trap cases the pointer and the counters do not move, and the trap handler decides what happens next. Two combinational read ports and one clocked write port see the same mapped view.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the pointer `cwp` is 0, `cansave` is NWIN-2, `canrestore` is 0, `otherwin` is 0, and every register reads 0.
- R2: Register number 0 reads 0 on both read ports, and a write to register 0 changes nothing.
- R3: A save with `cansave` non-zero sets `cwp` to (`cwp`+1) mod NWIN on the next edge, lowers `cansave` by one and raises `canrestore` by one.
- R4: A restore with `canrestore` non-zero sets `cwp` to (`cwp`-1) mod NWIN on the next edge, lowers `canrestore` by one and raises `cansave` by one.
- R5: A save while `cansave` is 0 drives `ovf_trap` high in the same cycle, and the pointer and counters do not change.
- R6: A restore while `canrestore` is 0 (and no save in the same cycle) drives `unf_trap` high in the same cycle, and the pointer and counters do not change.
- R7: `cansave + canrestore + otherwin` equals NWIN-2 in every cycle.
- R8: Register numbers 8..15 (outputs) of window w are the same storage as register numbers 24..31 (inputs) of window (w+1) mod NWIN, with the same offset within the group.
- R9: Register numbers 16..23 (locals) are private to each window. A value written in one window is not visible in another window, and it reads back again on return.
- R10: Register numbers 1..7 (globals) read the same in every window.
- R11: A write in the same cycle as a save or restore uses the window that was current before the move.
- R12: When save and restore are requested together, the save is taken and the restore is ignored. This also holds when the save traps.
- R13: The two read ports return their registers combinationally and independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_req | input | 1 | Move to the next window |
| restore_req | input | 1 | Move to the previous window |
| rs1_idx | input | 5 | Read port 1 register number |
| rs1_data | output | DW | Read port 1 data |
| rs2_idx | input | 5 | Read port 2 register number |
| rs2_data | output | DW | Read port 2 data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | DW | Write data |
| cwp | output | log2(NWIN) | Current window pointer |
| cansave | output | log2(NWIN) | Free windows available to save into |
| canrestore | output | log2(NWIN) | Windows available to restore to |
| otherwin | output | log2(NWIN) | Windows held for another context |
| ovf_trap | output | 1 | Save refused: overflow trap request |
| unf_trap | output | 1 | Restore refused: underflow trap request |

## Verification
A register write and a window move can fall in the same cycle. The write must then land in the window that was current before the move. The bench provokes this in two ways. It writes an output register together with a save and then reads the value from the new window's inputs. It also writes an input register together with a restore and then reads the value from the older window's outputs. A save and a restore can also be requested together, both with free windows and with none free. The expected pointer, counters and trap lines come from a window-level model that the bench keeps, and the counter sum is checked on every item.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int unsigned GRP_SIZE   = 8;
    localparam int unsigned WIN_STRIDE = 16;

    typedef enum logic [1:0] {
        GRP_GLB = 2'd0,
        GRP_OUT = 2'd1,
        GRP_LOC = 2'd2,
        GRP_IN  = 2'd3
    } reg_grp_e;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_SAVE    = 2'd1,
        OP_RESTORE = 2'd2
    } win_op_e;

    typedef struct packed {
        logic save;
        logic restore;
    } win_req_t;

    function automatic win_op_e decode_op(win_req_t rq);
        if (rq.save)         return OP_SAVE;
        else if (rq.restore) return OP_RESTORE;
        else                 return OP_NONE;
    endfunction

    // Physical layout: globals at 0..7, then one 16-entry block per window
    // holding its locals (first half) and its inputs (second half).
    function automatic int unsigned phys_of(int unsigned win, logic [4:0] rnum,
                                            int unsigned nwin);
        int unsigned nxt;
        int unsigned off;
        nxt = (win + 1) & (nwin - 1);
        off = 32'(rnum[2:0]);
        case (reg_grp_e'(rnum[4:3]))
            GRP_GLB: return off;
            GRP_OUT: return GRP_SIZE + nxt * WIN_STRIDE + GRP_SIZE + off;
            GRP_LOC: return GRP_SIZE + win * WIN_STRIDE + off;
            default: return GRP_SIZE + win * WIN_STRIDE + GRP_SIZE + off;
        endcase
    endfunction

endpackage

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int unsigned NWIN  = 8,
    parameter int unsigned PTR_W = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  win_req_t         req,
    output logic [PTR_W-1:0] cwp,
    output logic [PTR_W-1:0] cansave,
    output logic [PTR_W-1:0] canrestore,
    output logic [PTR_W-1:0] otherwin,
    output logic             ovf,
    output logic             unf
);
    localparam logic [PTR_W-1:0] FREE_INIT = PTR_W'(NWIN - 2);
    localparam logic [PTR_W-1:0] ONE       = PTR_W'(1);

    win_op_e op;

    always_comb begin
        op  = decode_op(req);
        ovf = (op == OP_SAVE)    && (cansave == '0);
        unf = (op == OP_RESTORE) && (canrestore == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp        <= '0;
            cansave    <= FREE_INIT;
            canrestore <= '0;
            otherwin   <= '0;
        end else begin
            case (op)
                OP_SAVE: begin
                    if (!ovf) begin
                        cwp        <= cwp + ONE;
                        cansave    <= cansave - ONE;
                        canrestore <= canrestore + ONE;
                    end
                end
                OP_RESTORE: begin
                    if (!unf) begin
                        cwp        <= cwp - ONE;
                        cansave    <= cansave + ONE;
                        canrestore <= canrestore - ONE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int unsigned NWIN   = 8,
    parameter int unsigned PTR_W  = $clog2(NWIN),
    parameter int unsigned PIDX_W = 8
) (
    input  logic [PTR_W-1:0]  win,
    input  logic [4:0]        rnum,
    output logic [PIDX_W-1:0] pidx,
    output logic              is_zero
);
    always_comb begin
        pidx    = PIDX_W'(phys_of(32'(win), rnum, NWIN));
        is_zero = (rnum == 5'd0);
    end
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
    parameter int unsigned DEPTH = 136,
    parameter int unsigned DW    = 32,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    output logic [DW-1:0] rd1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    logic [DW-1:0] mem [DEPTH];

    always_comb begin
        rd1 = mem[ra1];
        rd2 = mem[ra2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    parameter int unsigned DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    save_req,
    input  logic                    restore_req,
    input  logic [4:0]              rs1_idx,
    output logic [DW-1:0]           rs1_data,
    input  logic [4:0]              rs2_idx,
    output logic [DW-1:0]           rs2_data,
    input  logic                    wr_en,
    input  logic [4:0]              wr_idx,
    input  logic [DW-1:0]           wr_data,
    output logic [$clog2(NWIN)-1:0] cwp,
    output logic [$clog2(NWIN)-1:0] cansave,
    output logic [$clog2(NWIN)-1:0] canrestore,
    output logic [$clog2(NWIN)-1:0] otherwin,
    output logic                    ovf_trap,
    output logic                    unf_trap
);
    localparam int unsigned PTR_W  = $clog2(NWIN);
    localparam int unsigned DEPTH  = GRP_SIZE + NWIN * WIN_STRIDE;
    localparam int unsigned PIDX_W = $clog2(DEPTH);
    localparam int unsigned NPORT  = 3;   // read 1, read 2, write

    win_req_t          req;
    logic [4:0]        arch_idx [NPORT];
    logic [PIDX_W-1:0] phys_idx [NPORT];
    logic              zero_hit [NPORT];
    logic [DW-1:0]     raw1, raw2;
    logic              we_eff;

    assign req.save    = save_req;
    assign req.restore = restore_req;

    assign arch_idx[0] = rs1_idx;
    assign arch_idx[1] = rs2_idx;
    assign arch_idx[2] = wr_idx;

    rwin_ctrl #(.NWIN(NWIN), .PTR_W(PTR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .cwp        (cwp),
        .cansave    (cansave),
        .canrestore (canrestore),
        .otherwin   (otherwin),
        .ovf        (ovf_trap),
        .unf        (unf_trap)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwin_map #(.NWIN(NWIN), .PTR_W(PTR_W), .PIDX_W(PIDX_W)) u_map (
            .win     (cwp),
            .rnum    (arch_idx[p]),
            .pidx    (phys_idx[p]),
            .is_zero (zero_hit[p])
        );
    end

    assign we_eff = wr_en && !zero_hit[2];

    rwin_store #(.DEPTH(DEPTH), .DW(DW), .AW(PIDX_W)) u_store (
        .clk (clk),
        .rst (rst),
        .ra1 (phys_idx[0]),
        .rd1 (raw1),
        .ra2 (phys_idx[1]),
        .rd2 (raw2),
        .we  (we_eff),
        .wa  (phys_idx[2]),
        .wd  (wr_data)
    );

    assign rs1_data = zero_hit[0] ? '0 : raw1;
    assign rs2_data = zero_hit[1] ? '0 : raw2;
endmodule

// File: rtl/rwin_chk.sv
module rwin_chk #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned DW   = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    save_req,
    input logic                    restore_req,
    input logic [4:0]              rs1_idx,
    input logic [DW-1:0]           rs1_data,
    input logic [4:0]              rs2_idx,
    input logic [DW-1:0]           rs2_data,
    input logic [$clog2(NWIN)-1:0] cwp,
    input logic [$clog2(NWIN)-1:0] cansave,
    input logic [$clog2(NWIN)-1:0] canrestore,
    input logic [$clog2(NWIN)-1:0] otherwin,
    input logic                    ovf_trap,
    input logic                    unf_trap
);
    localparam int unsigned PTR_W = $clog2(NWIN);

    // R7
    sum_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(cansave) + 32'(canrestore) + 32'(otherwin)) == NWIN - 2);

    // R2
    zero_rd_chk: assert property (@(posedge clk) disable iff (rst)
        ((rs1_idx == 5'd0) |-> (rs1_data == '0)) and
        ((rs2_idx == 5'd0) |-> (rs2_data == '0)));

    // R3
    save_step_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && cansave != '0) |=>
        (cwp == PTR_W'($past(cwp) + 1'b1)) &&
        (cansave == PTR_W'($past(cansave) - 1'b1)) &&
        (canrestore == PTR_W'($past(canrestore) + 1'b1)));

    // R4
    rest_step_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && canrestore != '0) |=>
        (cwp == PTR_W'($past(cwp) - 1'b1)) &&
        (canrestore == PTR_W'($past(canrestore) - 1'b1)) &&
        (cansave == PTR_W'($past(cansave) + 1'b1)));

    // R5
    ovf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (save_req && cansave == '0) |-> (ovf_trap && !unf_trap));

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |=> ($stable(cwp) && $stable(cansave) && $stable(canrestore)));

    // R6
    unf_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && canrestore == '0) |-> (unf_trap && !ovf_trap));

    // R6
    unf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        unf_trap |=> ($stable(cwp) && $stable(cansave) && $stable(canrestore)));
endmodule

bind rwin_regfile rwin_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .save_req    (save_req),
    .restore_req (restore_req),
    .rs1_idx     (rs1_idx),
    .rs1_data    (rs1_data),
    .rs2_idx     (rs2_idx),
    .rs2_data    (rs2_data),
    .cwp         (cwp),
    .cansave     (cansave),
    .canrestore  (canrestore),
    .otherwin    (otherwin),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap)
);

// File: tb/rwin_regfile_bench.sv
module rwin_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          save_req = 1'b0, restore_req = 1'b0, wr_en = 1'b0;
    logic [4:0]    rs1_idx = '0, rs2_idx = '0, wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rs1_data, rs2_data;
    logic [2:0]    cwp, cansave, canrestore, otherwin;
    logic          ovf_trap, unf_trap;

    always #(CLK_PERIOD/2) clk = ~clk;

    rwin_regfile #(.NWIN(NW), .DW(DW)) u_rwin_regfile (
        .clk(clk), .rst(rst), .save_req(save_req), .restore_req(restore_req),
        .rs1_idx(rs1_idx), .rs1_data(rs1_data), .rs2_idx(rs2_idx), .rs2_data(rs2_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cwp(cwp), .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    typedef struct {
        string         req;
        int            cwp, cs, cr, ow;
        bit            ovf, unf;
        logic [DW-1:0] d1, d2;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    // window-level reference state
    logic [DW-1:0] m_glob [8];
    logic [DW-1:0] m_loc  [NW][8];
    logic [DW-1:0] m_in   [NW][8];
    int m_cwp, m_cs, m_cr, m_ow;

    function automatic logic [DW-1:0] m_read(logic [4:0] r);
        if (r == 0)       return '0;
        else if (r < 8)   return m_glob[r];
        else if (r < 16)  return m_in[(m_cwp + 1) % NW][r - 8];
        else if (r < 24)  return m_loc[m_cwp][r - 16];
        else              return m_in[m_cwp][r - 24];
    endfunction

    task automatic m_write(logic [4:0] r, logic [DW-1:0] v);
        if (r == 0)      ;
        else if (r < 8)  m_glob[r] = v;
        else if (r < 16) m_in[(m_cwp + 1) % NW][r - 8] = v;
        else if (r < 24) m_loc[m_cwp][r - 16] = v;
        else             m_in[m_cwp][r - 24] = v;
    endtask

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected outputs pushed for that cycle
    task automatic step(bit sv, bit rs, bit we, logic [4:0] widx, logic [DW-1:0] wd,
                        logic [4:0] a1, logic [4:0] a2, string req);
        exp_t e;
        @(negedge clk);
        save_req = sv; restore_req = rs; wr_en = we; wr_idx = widx; wr_data = wd;
        rs1_idx = a1; rs2_idx = a2;
        e.req = req;
        e.ovf = sv && (m_cs == 0);
        e.unf = rs && !sv && (m_cr == 0);
        e.d1  = m_read(a1);
        e.d2  = m_read(a2);
        e.cwp = m_cwp; e.cs = m_cs; e.cr = m_cr; e.ow = m_ow;
        q.push_back(e);
        if (we) m_write(widx, wd);
        if (sv) begin
            if (m_cs != 0) begin m_cwp = (m_cwp + 1) % NW; m_cs--; m_cr++; end
        end else if (rs) begin
            if (m_cr != 0) begin m_cwp = (m_cwp + NW - 1) % NW; m_cr--; m_cs++; end
        end
    endtask

    // monitor: compares queued expectations once outputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, "cwp",        cwp,        e.cwp);
                chk(e.req, "cansave",    cansave,    e.cs);
                chk(e.req, "canrestore", canrestore, e.cr);
                chk(e.req, "otherwin",   otherwin,   e.ow);
                chk(e.req, "ovf_trap",   ovf_trap,   e.ovf);
                chk(e.req, "unf_trap",   unf_trap,   e.unf);
                chk(e.req, "rs1_data",   rs1_data,   e.d1);
                chk(e.req, "rs2_data",   rs2_data,   e.d2);
                // R7 counter sum on every item
                chk("R7", "counter sum", cansave + canrestore + otherwin, NW - 2);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_glob[i] = '0;
        for (int w = 0; w < NW; w++)
            for (int i = 0; i < 8; i++) begin m_loc[w][i] = '0; m_in[w][i] = '0; end
        m_cwp = 0; m_cs = NW - 2; m_cr = 0; m_ow = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        step(0, 0, 0, 0, 0,         5, 20, "R1");
        step(0, 0, 1, 0, 'hDEAD,    0, 0,  "R2");
        step(0, 0, 1, 3, 'h33,      0, 3,  "R2");
        step(0, 0, 1, 10, 'hA2,     3, 0,  "R10");
        step(0, 0, 1, 17, 'h11,     10, 3, "R13");
        step(1, 0, 0, 0, 0,         17, 10, "R3");
        step(0, 0, 1, 17, 'h77,     26, 17, "R8");
        step(0, 0, 0, 0, 0,         3, 17, "R10");
        step(0, 1, 0, 0, 0,         0, 0,  "R4");
        step(0, 0, 0, 0, 0,         17, 10, "R9");
        step(0, 1, 0, 0, 0,         17, 0, "R6");
        step(0, 0, 0, 0, 0,         17, 3, "R6");
        step(1, 0, 1, 8, 'hBEEF,    0, 0,  "R11");
        step(0, 0, 0, 0, 0,         24, 8, "R11");
        step(1, 1, 0, 0, 0,         24, 0, "R12");
        step(0, 1, 1, 24, 'hC0DE,   0, 0,  "R11");
        step(0, 0, 0, 0, 0,         8, 24, "R11");
        for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0, 3, 17, "R3");
        step(1, 0, 0, 0, 0,         3, 0,  "R5");
        step(0, 0, 0, 0, 0,         17, 0, "R5");
        step(1, 1, 0, 0, 0,         0, 3,  "R12");
        for (int k = 0; k < 6; k++) step(0, 1, 0, 0, 0, 17, 26, "R4");
        step(0, 1, 0, 0, 0,         17, 10, "R6");
        step(0, 0, 0, 0, 0,         17, 10, "R9");

        @(negedge clk);
        save_req = 0; restore_req = 0; wr_en = 0;
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule